// File: doc/BRIEF.md
# Panel Serial Register Sequencer

This block configures a display panel over a three-wire link that only transmits: an active-low select, a serial clock and a data line. Each transaction is one 16-bit word. The register address is in the high byte and the value is in the low byte. The word is shifted out starting from bit 15. The panel samples data on each rising clock edge. Between transactions the select line is high, the clock rests high and the data line rests low.

Two built-in scripts are held in the block. A single-cycle `on_req` pulse runs a five-write power-up script. A single-cycle `off_req` pulse runs a one-write power-down script. `busy` is high while a script runs. `done` pulses for one cycle when a script ends. The serial bit rate comes from the `CLK_DIV` parameter: each clock half-period lasts `CLK_DIV` system clocks.

Top module: `panel_cfg_seq`

## Requirements
- R1: Each word is sent most significant bit first. Bits 15..8 hold the register address and bits 7..0 hold the value. Exactly 16 data bits are sent per word.
- R2: `cfg_cs_n` goes low for exactly 32*CLK_DIV system clocks per word and returns high after the last bit of that word.
- R3: While `cfg_cs_n` is high, `cfg_sclk` is 1 and `cfg_sdat` is 0.
- R4: Every bit has a clock-low phase of exactly CLK_DIV clocks, during which the bit is placed on `cfg_sdat`. It is followed by a clock-high phase of exactly CLK_DIV clocks, during which `cfg_sdat` does not change.
- R5: `on_req` sends, in order: 0x051E, 0x055E, 0x078D, 0x1301, 0x055F.
- R6: `off_req` sends the single word 0x055E.
- R7: Between consecutive words of one script, `cfg_cs_n` stays high for at least 2*CLK_DIV clocks.
- R8: A request that arrives while `busy` is 1 is ignored. The running script is unchanged and no extra words follow it.
- R9: When `on_req` and `off_req` are both 1 while idle, the power-down script runs.
- R10: `busy` is 1 from the clock after an accepted request until the clock in which `done` is 1. `done` is 1 for exactly one clock, and `busy` is 0 in that clock.
- R11: Synchronous active-high `rst` drives `cfg_cs_n`=1, `cfg_sclk`=1 and `cfg_sdat`=0, and clears `busy` and `done`, even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req | input | 1 | One-cycle pulse that starts the power-up script |
| off_req | input | 1 | One-cycle pulse that starts the power-down script |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle pulse when a script ends |
| cfg_cs_n | output | 1 | Serial select, active low |
| cfg_sclk | output | 1 | Serial clock, rests high |
| cfg_sdat | output | 1 | Serial data, rests low |

## Verification
The assertions rely on the requests being synchronous to `clk` and on `CLK_DIV` being at least 1. They make no assumption about how long a request is held, because requests seen while busy are dropped. The bench drives each request for exactly one clock, starting from a negative edge. It sends the overlapping and mid-script requests deliberately, so that the ignore and priority rules are exercised rather than avoided. It applies reset only at a negative edge, including once while `cfg_cs_n` is low.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic {SCR_ON = 1'b0, SCR_OFF = 1'b1} script_e;

    typedef struct packed {
        logic        active;
        logic        gap;
        logic        phase;
        logic [3:0]  bitn;
        logic [15:0] sr;
        logic        cs_n;
        logic        sclk;
        logic        sdat;
        logic        fdone;
    } shf_t;

    typedef struct packed {
        logic       busy;
        script_e    sel;
        logic [2:0] idx;
        logic       inflight;
        logic       done;
    } seq_t;

    function automatic logic [2:0] script_last(script_e s);
        return (s == SCR_OFF) ? 3'd0 : 3'd4;
    endfunction

    function automatic logic [15:0] script_word(script_e s, logic [2:0] idx);
        logic [15:0] w;
        if (s == SCR_OFF) begin
            w = 16'h055E;
        end else begin
            case (idx)
                3'd0:    w = 16'h051E;
                3'd1:    w = 16'h055E;
                3'd2:    w = 16'h078D;
                3'd3:    w = 16'h1301;
                default: w = 16'h055F;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/pcs_divider.sv
module pcs_divider #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    a_r4_idle_count_zero: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> cnt_q == '0);

endmodule

// File: rtl/pcs_shifter.sv
module pcs_shifter
    import pcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] word,
    input  logic        tick,
    output logic        running,
    output logic        fdone,
    output logic        cs_n,
    output logic        sclk,
    output logic        sdat
);
    shf_t d, q;

    always_comb begin
        d       = q;
        d.fdone = 1'b0;
        if (!q.active && !q.gap) begin
            if (start) begin
                d.active = 1'b1;
                d.phase  = 1'b0;
                d.bitn   = 4'd15;
                d.cs_n   = 1'b0;
                d.sclk   = 1'b0;
                d.sdat   = word[15];
                d.sr     = {word[14:0], 1'b0};
            end
        end else if (tick) begin
            if (q.active) begin
                if (!q.phase) begin
                    d.sclk  = 1'b1;
                    d.phase = 1'b1;
                end else if (q.bitn == 4'd0) begin
                    d.active = 1'b0;
                    d.gap    = 1'b1;
                    d.phase  = 1'b0;
                    d.cs_n   = 1'b1;
                    d.sdat   = 1'b0;
                end else begin
                    d.sclk  = 1'b0;
                    d.phase = 1'b0;
                    d.sdat  = q.sr[15];
                    d.sr    = {q.sr[14:0], 1'b0};
                    d.bitn  = q.bitn - 4'd1;
                end
            end else begin
                if (!q.phase) begin
                    d.phase = 1'b1;
                end else begin
                    d.gap   = 1'b0;
                    d.phase = 1'b0;
                    d.fdone = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.cs_n <= 1'b1;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign running = q.active | q.gap;
    assign fdone   = q.fdone;
    assign cs_n    = q.cs_n;
    assign sclk    = q.sclk;
    assign sdat    = q.sdat;

    a_r3_idle_levels: assert property (@(posedge clk) disable iff (rst)
        q.cs_n |-> (q.sclk && !q.sdat));
    a_r4_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (!q.cs_n && q.sclk && $past(!q.cs_n && q.sclk)) |-> $stable(q.sdat));
    a_r2_no_start_midword: assert property (@(posedge clk) disable iff (rst)
        start |-> (q.cs_n && !q.gap));

endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
    import pcs_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic on_req,
    input  logic off_req,
    output logic busy,
    output logic done,
    output logic cfg_cs_n,
    output logic cfg_sclk,
    output logic cfg_sdat
);
    seq_t        d, q;
    logic        start;
    logic        tick;
    logic        running;
    logic        fdone;
    logic [15:0] word;

    assign start = q.busy && !q.inflight;
    assign word  = script_word(q.sel, q.idx);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (off_req || on_req) begin
                d.busy     = 1'b1;
                d.sel      = off_req ? SCR_OFF : SCR_ON;
                d.idx      = 3'd0;
                d.inflight = 1'b0;
            end
        end else begin
            if (start) d.inflight = 1'b1;
            if (fdone) begin
                d.inflight = 1'b0;
                if (q.idx == script_last(q.sel)) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.idx = q.idx + 3'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    pcs_divider #(.CLK_DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (running),
        .tick (tick)
    );

    pcs_shifter u_shf (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .word    (word),
        .tick    (tick),
        .running (running),
        .fdone   (fdone),
        .cs_n    (cfg_cs_n),
        .sclk    (cfg_sclk),
        .sdat    (cfg_sdat)
    );

    assign busy = q.busy;
    assign done = q.done;

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        q.done |=> !q.done);
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        q.done |-> (!q.busy && $past(q.busy)));
    a_r8_script_locked: assert property (@(posedge clk) disable iff (rst)
        (q.busy && $past(q.busy)) |-> $stable(q.sel));
    a_r9_off_wins: assert property (@(posedge clk) disable iff (rst)
        (!q.busy && on_req && off_req) |=> (q.busy && q.sel == SCR_OFF));
    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
        q.busy |-> (q.idx <= script_last(q.sel)));

endmodule

// File: tb/tb_panel_cfg_seq.sv
module tb_panel_cfg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic on_req = 1'b0, off_req = 1'b0;
    logic busy, done, cfg_cs_n, cfg_sclk, cfg_sdat;

    int n_checks = 0;
    int n_fail   = 0;

    panel_cfg_seq #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .on_req(on_req), .off_req(off_req),
        .busy(busy), .done(done),
        .cfg_cs_n(cfg_cs_n), .cfg_sclk(cfg_sclk), .cfg_sdat(cfg_sdat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // vector: {on_req, off_req}; off bit set means power-down script expected
    localparam logic [1:0] VEC [5] = '{2'b10, 2'b01, 2'b11, 2'b10, 2'b01};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit off, input int i);
        logic [15:0] on_list [5] = '{16'h051E, 16'h055E, 16'h078D, 16'h1301, 16'h055F};
        return off ? 16'h055E : on_list[i];
    endfunction

    // link monitor, sampled on the falling edge
    logic [15:0] frames [8];
    int nfr = 0;
    int idle_err = 0;
    bit pcs = 1, psclk = 1, psdat = 0;
    int cs_len, low_len, high_len, nbits, perr, gap;
    logic [15:0] shreg;

    always @(negedge clk) begin
        if (rst) begin
            pcs = 1; psclk = 1; psdat = 0; nbits = 0;
        end else begin
            if (cfg_cs_n && (!cfg_sclk || cfg_sdat)) idle_err++;
            if (pcs && !cfg_cs_n) begin
                if (nfr > 0) check(gap >= 2*DIV, "R7 gap", gap, 2*DIV);
                cs_len = 0; low_len = 0; high_len = 0; nbits = 0; perr = 0; shreg = '0;
            end
            if (!cfg_cs_n) begin
                cs_len++;
                if (cfg_sclk) high_len++; else low_len++;
                if (!pcs && !psclk && cfg_sclk) begin
                    shreg = {shreg[14:0], cfg_sdat};
                    nbits++;
                    if (low_len != DIV) perr++;
                    low_len = 0;
                end
                if (!pcs && psclk && !cfg_sclk) begin
                    if (high_len != DIV) perr++;
                    high_len = 0;
                end
                if (!pcs && psclk && cfg_sclk && cfg_sdat != psdat) perr++;
                gap = 0;
            end else begin
                if (!pcs) begin
                    if (high_len != DIV) perr++;
                    check(cs_len == 32*DIV, "R2 select low length", cs_len, 32*DIV);
                    check(nbits == 16 && perr == 0, "R4 bit phases", perr, 0);
                    if (nfr < 8) frames[nfr] = shreg;
                    nfr++;
                end
                gap++;
            end
            pcs = cfg_cs_n; psclk = cfg_sclk; psdat = cfg_sdat;
        end
    end

    task automatic pulse(input logic on_v, input logic off_v);
        @(negedge clk);
        on_req = on_v; off_req = off_v;
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int cyc;
        repeat (4) @(negedge clk);
        // R11: levels during reset
        check(cfg_cs_n && cfg_sclk && !cfg_sdat, "R11 reset levels",
              {cfg_cs_n, cfg_sclk, cfg_sdat}, 3'b110);
        check(!busy && !done, "R11 reset busy/done", {busy, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(cfg_cs_n && cfg_sclk && !cfg_sdat, "R3 idle after reset",
              {cfg_cs_n, cfg_sclk, cfg_sdat}, 3'b110);

        // table walk: R1 R5 R6 R9 R10
        for (int v = 0; v < 5; v++) begin
            bit off_exp;
            off_exp = VEC[v][0];
            nfr = 0;
            pulse(VEC[v][1], VEC[v][0]);
            check(busy, "R10 busy after request", busy, 1);
            wait_done(cyc);
            check(done && !busy, "R10 done with busy low", {done, busy}, 2'b10);
            @(negedge clk);
            check(!done, "R10 done single cycle", done, 0);
            check(nfr == (off_exp ? 1 : 5), off_exp ? "R6/R9 word count" : "R5 word count",
                  nfr, off_exp ? 1 : 5);
            for (int i = 0; i < nfr && i < 5; i++)
                check(frames[i] == exp_word(off_exp, i), "R1 word value",
                      frames[i], exp_word(off_exp, i));
            repeat (5) @(negedge clk);
        end

        // R8: request while busy is ignored (off running, on arrives)
        nfr = 0;
        pulse(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        pulse(1'b1, 1'b0);
        wait_done(cyc);
        repeat (200) @(negedge clk);
        check(nfr == 1 && !busy, "R8 on ignored while busy", nfr, 1);

        // R8: off arrives during power-up script
        nfr = 0;
        pulse(1'b1, 1'b0);
        repeat (150) @(negedge clk);
        pulse(1'b0, 1'b1);
        wait_done(cyc);
        repeat (200) @(negedge clk);
        check(nfr == 5, "R8 off ignored while busy", nfr, 5);
        check(frames[4] == 16'h055F, "R8 script unchanged", frames[4], 16'h055F);

        // R3 over the whole run
        check(idle_err == 0, "R3 idle levels", idle_err, 0);

        // R11: reset in the middle of a word
        pulse(1'b1, 1'b0);
        while (cfg_cs_n) @(negedge clk);
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(cfg_cs_n && cfg_sclk && !cfg_sdat, "R11 mid-word reset levels",
              {cfg_cs_n, cfg_sclk, cfg_sdat}, 3'b110);
        check(!busy, "R11 mid-word reset busy", busy, 0);
        rst = 1'b0;
        repeat (50) @(negedge clk);
        check(cfg_cs_n && !busy, "R11 stays idle after reset", {cfg_cs_n, busy}, 2'b10);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule